// File: doc/BRIEF.md
# Prime-Length DCT Input Restructuring Stage

This block sits at the front of a prime-length DCT engine. It receives one block of N signed real samples (N = 7 by default), one sample per cycle whenever a valid strobe is high. Once a block is complete, it forms an auxiliary sequence with an alternating-sign suffix sum. It then streams out the operand pairs that a cyclic convolution and a pseudo-cyclic convolution need. Each output beat carries a pair difference, a pair sum and the auxiliary term of index zero. That term is handed on because every transform output later adds it.

The pairing comes from an index map built on a primitive root G of N. Output beat j joins the auxiliary terms at indices G^j mod N and G^(j+M) mod N, where M = (N-1)/2. Incoming samples fill one register bank while the other bank is read. A new block can therefore start on the cycle after the previous block's last sample, with no idle cycle in between. Convolution, coefficient multiplication and output scaling are handled further down the chain.

Top module: `dctpre_top`

## Requirements
- R1: After reset `outValid` and `outFirst` are 0, and no output beat appears until N samples have been accepted.
- R2: The auxiliary sequence is xa(N-1) = x(N-1) and xa(i) = (-1)^i·x(i) + xa(i+1) for i = N-2 down to 0. It is held as a signed value SW + ceil(log2 N) bits wide.
- R3: Output beat j (j = 1..M) carries `pairDiff` = xa(phi(j)) - xa(phi(j+M)), with phi(k) = G^k mod N. For N = 7 and G = 3 the pairs in order are (3,4), (2,5), (6,1).
- R4: In the same beat, `pairSum` = xa(phi(j)) + xa(phi(j+M)).
- R5: `baseOut` equals xa(0) of the block on every beat of that block and stays constant across those beats.
- R6: `outFirst` is 1 on beat j = 1 only, and never without `outValid`.
- R7: Each block yields exactly M beats on consecutive cycles. The first beat is registered on the rising edge right after the edge that accepts the block's last sample.
- R8: Cycles with `inValid` low have no effect, whatever is on `sampleIn`. Blocks may follow back to back with no idle cycle, and each one still yields its full set of beats.
- R9: Full-scale inputs (all +2047, all -2048, or alternating so that every term adds) give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept `sampleIn` on this edge |
| sampleIn | input | SW (12) | Signed input sample, index 0 first |
| outValid | output | 1 | An operand beat is present |
| outFirst | output | 1 | Marks the first beat of a block |
| pairDiff | output | SW+ceil(log2 N)+1 (16) | Signed difference of the current pair |
| pairSum | output | SW+ceil(log2 N)+1 (16) | Signed sum of the current pair |
| baseOut | output | SW+ceil(log2 N) (15) | Signed xa(0) of the current block |

## Verification
A stale or swapped bank select shows on the first beat of a block: all three data outputs carry the previous block's values. A fill counter that is off by one shifts every sample into the wrong slot, so `baseOut` and every pair are wrong from the first beat. A step counter that is off shows within one block as a repeated pair, a missing pair, a fourth `outValid` cycle or a misplaced `outFirst`. A sign error in the recursion differs from the expected xa(0) as soon as any odd-index sample is non-zero.

// File: rtl/dctpre_pkg.sv
package dctpre_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store sampleIn into the fill bank
    logic wrBank;  // bank being filled
    logic rdBank;  // bank being restructured
    logic emit;    // produce an output beat this cycle
    logic first;   // beat is the first of its block
  } ctrl_t;

  // k-th power of the primitive root, reduced modulo n
  function automatic int phiOf(input int g, input int k, input int n);
    int r;
    r = 1;
    for (int t = 0; t < k; t++) r = (r * g) % n;
    return r;
  endfunction

endpackage

// File: rtl/dctpre_control.sv
module dctpre_control
  import dctpre_pkg::*;
#(
  parameter int N  = 7,
  parameter int M  = (N - 1) / 2,
  parameter int IW = $clog2(N),
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output ctrl_t         ctl,
  output logic [IW-1:0] wrIdx,
  output logic [PW-1:0] step
);

  logic [IW-1:0] fillCnt;
  logic          fillBank;
  logic          procActive;
  logic          procBank;
  logic [PW-1:0] stepCnt;
  logic          lastSlot;

  assign lastSlot = inValid && (fillCnt == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt    <= '0;
      fillBank   <= 1'b0;
      procActive <= 1'b0;
      procBank   <= 1'b0;
      stepCnt    <= '0;
    end else begin
      if (inValid) fillCnt <= lastSlot ? '0 : fillCnt + 1'b1;
      if (procActive) begin
        if (stepCnt == PW'(M - 1)) procActive <= 1'b0;
        else                       stepCnt    <= stepCnt + 1'b1;
      end
      if (lastSlot) begin
        fillBank   <= ~fillBank;
        procBank   <= fillBank;
        procActive <= 1'b1;
        stepCnt    <= '0;
      end
    end
  end

  always_comb begin
    ctl.wrEn   = inValid;
    ctl.wrBank = fillBank;
    ctl.rdBank = procBank;
    ctl.emit   = procActive;
    ctl.first  = procActive && (stepCnt == '0);
  end

  assign wrIdx = fillCnt;
  assign step  = stepCnt;

endmodule

// File: rtl/dctpre_datapath.sv
module dctpre_datapath
  import dctpre_pkg::*;
#(
  parameter int N  = 7,
  parameter int G  = 3,
  parameter int SW = 12,
  parameter int M  = (N - 1) / 2,
  parameter int XW = SW + $clog2(N),
  parameter int OW = XW + 1,
  parameter int IW = $clog2(N),
  parameter int PW = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctl,
  input  logic [IW-1:0]        wrIdx,
  input  logic [PW-1:0]        step,
  input  logic signed [SW-1:0] sampleIn,
  output logic                 outValid,
  output logic                 outFirst,
  output logic signed [OW-1:0] pairDiff,
  output logic signed [OW-1:0] pairSum,
  output logic signed [XW-1:0] baseOut
);

  localparam int EXT = XW - SW;

  logic signed [SW-1:0] bankMem [2][N];
  logic signed [XW-1:0] ext [N];
  logic signed [XW-1:0] xa [N];
  logic signed [XW-1:0] acc;
  logic signed [XW-1:0] opA, opB;
  logic signed [OW-1:0] wideA, wideB;

  // ping-pong sample storage
  always_ff @(posedge clk) begin
    if (ctl.wrEn) bankMem[ctl.wrBank][wrIdx] <= sampleIn;
  end

  // sign-extend the bank under restructuring
  for (genvar i = 0; i < N; i++) begin : gExt
    assign ext[i] = {{EXT{bankMem[ctl.rdBank][i][SW-1]}}, bankMem[ctl.rdBank][i]};
  end

  // alternating-sign suffix sum, highest index first
  always_comb begin
    acc = '0;
    for (int i = N - 1; i >= 0; i--) begin
      acc   = ((i % 2) == 1) ? acc - ext[i] : acc + ext[i];
      xa[i] = acc;
    end
  end

  // primitive-root permutation: one multiplexer per operand
  always_comb begin
    opA = '0;
    opB = '0;
    for (int j = 0; j < M; j++) begin
      if (step == PW'(j)) begin
        opA = xa[phiOf(G, j + 1, N)];
        opB = xa[phiOf(G, j + 1 + M, N)];
      end
    end
  end

  assign wideA = {opA[XW-1], opA};
  assign wideB = {opB[XW-1], opB};

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      pairDiff <= '0;
      pairSum  <= '0;
      baseOut  <= '0;
    end else begin
      outValid <= ctl.emit;
      outFirst <= ctl.first;
      if (ctl.emit) begin
        pairDiff <= wideA - wideB;
        pairSum  <= wideA + wideB;
        baseOut  <= xa[0];
      end
    end
  end

endmodule

// File: rtl/dctpre_top.sv
module dctpre_top
  import dctpre_pkg::*;
#(
  parameter int N  = 7,
  parameter int G  = 3,
  parameter int SW = 12
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 inValid,
  input  logic signed [SW-1:0]                 sampleIn,
  output logic                                 outValid,
  output logic                                 outFirst,
  output logic signed [SW+$clog2(N):0]         pairDiff,
  output logic signed [SW+$clog2(N):0]         pairSum,
  output logic signed [SW+$clog2(N)-1:0]       baseOut
);

  localparam int M  = (N - 1) / 2;
  localparam int XW = SW + $clog2(N);
  localparam int OW = XW + 1;
  localparam int IW = $clog2(N);
  localparam int PW = (M > 1) ? $clog2(M) : 1;

  ctrl_t         ctl;
  logic [IW-1:0] wrIdx;
  logic [PW-1:0] step;

  dctpre_control #(.N(N), .M(M), .IW(IW), .PW(PW)) uCtl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctl     (ctl),
    .wrIdx   (wrIdx),
    .step    (step)
  );

  dctpre_datapath #(
    .N(N), .G(G), .SW(SW), .M(M), .XW(XW), .OW(OW), .IW(IW), .PW(PW)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .wrIdx    (wrIdx),
    .step     (step),
    .sampleIn (sampleIn),
    .outValid (outValid),
    .outFirst (outFirst),
    .pairDiff (pairDiff),
    .pairSum  (pairSum),
    .baseOut  (baseOut)
  );

endmodule

// File: rtl/dctpre_checker.sv
module dctpre_checker #(
  parameter int N  = 7,
  parameter int XW = 15
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 outValid,
  input logic                 outFirst,
  input logic                 diffLsb,
  input logic                 sumLsb,
  input logic signed [XW-1:0] baseOut
);

  localparam int M = (N - 1) / 2;

  int acceptCnt;   // position within the block being filled
  int acceptTotal; // samples since reset, saturating at N
  int runCnt;      // beats already seen in the current block

  always_ff @(posedge clk) begin
    if (rst) begin
      acceptCnt   <= 0;
      acceptTotal <= 0;
      runCnt      <= 0;
    end else begin
      if (inValid) begin
        acceptCnt <= (acceptCnt == N - 1) ? 0 : acceptCnt + 1;
        if (acceptTotal < N) acceptTotal <= acceptTotal + 1;
      end
      if (outValid && outFirst) runCnt <= 1;
      else if (outValid)        runCnt <= runCnt + 1;
      else                      runCnt <= 0;
    end
  end

  assert_idle_until_block_R1: assert property (@(posedge clk) disable iff (rst)
    (acceptTotal < N) |-> !outValid);

  assert_launch_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && acceptCnt == N - 1) |-> ##2 (outValid && outFirst));

  assert_beats_contiguous_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outFirst) |-> $past(outValid));

  assert_beat_count_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outFirst) |-> (runCnt < M));

  assert_first_has_valid_R6: assert property (@(posedge clk) disable iff (rst)
    outFirst |-> outValid);

  assert_base_held_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outFirst) |-> $stable(baseOut));

  assert_sum_diff_parity_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (diffLsb == sumLsb));

endmodule

bind dctpre_top dctpre_checker #(.N(N), .XW(XW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outFirst (outFirst),
  .diffLsb  (pairDiff[0]),
  .sumLsb   (pairSum[0]),
  .baseOut  (baseOut)
);

// File: tb/sim_dctpre_top.sv
`timescale 1ns/1ps
module sim_dctpre_top;

  localparam int N  = 7;
  localparam int G  = 3;
  localparam int SW = 12;
  localparam int M  = (N - 1) / 2;
  localparam int XW = SW + $clog2(N);
  localparam int OW = XW + 1;
  localparam int NB = 4;

  // stimulus table; expected beats are derived from R2/R3 by the model below
  localparam int STIM [NB][N] = '{
    '{1, 2, 3, 4, 5, 6, 7},
    '{-100, 523, -2048, 2047, 0, 17, -900},
    '{300, -301, 1200, -5, 64, -1999, 888},
    '{-1, -1, -1, -1, -1, -1, -1}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic                 outValid, outFirst;
  logic signed [OW-1:0] pairDiff, pairSum;
  logic signed [XW-1:0] baseOut;

  int    nChk = 0;
  int    nBad = 0;
  bit    finished = 1'b0;
  int    qDiff[$], qSum[$], qBase[$], qFirst[$];
  string qTag[$];

  always #4 clk = ~clk;

  dctpre_top #(.N(N), .G(G), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .sampleIn(sampleIn),
    .outValid(outValid), .outFirst(outFirst),
    .pairDiff(pairDiff), .pairSum(pairSum), .baseOut(baseOut)
  );

  task automatic check(input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int rootPow(input int k);
    int r;
    r = 1;
    for (int t = 0; t < k; t++) r = (r * G) % N;
    return r;
  endfunction

  // reference model: suffix sum, then pairs through the root map
  task automatic pushBlock(input int s[N], input string tag);
    int xa[N];
    xa[N-1] = s[N-1];
    for (int i = N - 2; i >= 0; i--) xa[i] = (((i % 2) == 1) ? -s[i] : s[i]) + xa[i+1];
    for (int j = 1; j <= M; j++) begin
      int a;
      int b;
      a = rootPow(j);
      b = rootPow(j + M);
      qDiff.push_back(xa[a] - xa[b]);
      qSum.push_back(xa[a] + xa[b]);
      qBase.push_back(xa[0]);
      qFirst.push_back((j == 1) ? 1 : 0);
      qTag.push_back(tag);
    end
  endtask

  task automatic feed(input bit v, input int x);
    inValid  = v;
    sampleIn = SW'(x);
    @(negedge clk);
  endtask

  task automatic sendBlock(input int s[N]);
    for (int i = 0; i < N; i++) feed(1'b1, s[i]);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  // output collector
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (qDiff.size() == 0) begin
        check("R7 beat with no block pending", 1, 0);
      end else begin
        string t;
        t = qTag.pop_front();
        check({t, " R3 pair difference"}, int'(pairDiff), qDiff.pop_front());
        check({t, " R4 pair sum"},        int'(pairSum),  qSum.pop_front());
        check({t, " R2 R5 base term"},    int'(baseOut),  qBase.pop_front());
        check({t, " R6 first flag"},      int'(outFirst), qFirst.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int s[N];
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outFirst in reset", int'(outFirst), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 and R7: no beat before the block completes, then exact timing
    pushBlock(STIM[0], "R7 timing");
    for (int i = 0; i < N - 1; i++) begin
      feed(1'b1, STIM[0][i]);
      check("R1 no beat before block complete", int'(outValid), 0);
    end
    feed(1'b1, STIM[0][N-1]);
    check("R7 no beat on accepting edge", int'(outValid), 0);
    feed(1'b0, 0);
    check("R7 first beat valid", int'(outValid), 1);
    check("R6 first beat flagged", int'(outFirst), 1);
    feed(1'b0, 0);
    check("R7 second beat valid", int'(outValid), 1);
    feed(1'b0, 0);
    check("R7 third beat valid", int'(outValid), 1);
    feed(1'b0, 0);
    check("R7 no fourth beat", int'(outValid), 0);

    // table walk, blocks back to back (R8)
    for (int b = 0; b < NB; b++) pushBlock(STIM[b], "R8 back-to-back");
    for (int b = 0; b < NB; b++) sendBlock(STIM[b]);

    // R8: gaps with junk on sampleIn are ignored
    s = '{5, -7, 11, -13, 17, -19, 23};
    pushBlock(s, "R8 gaps ignored");
    for (int i = 0; i < N; i++) begin
      feed(1'b0, 1234);
      feed(1'b1, s[i]);
      feed(1'b0, -2048);
    end

    // R9 full-scale patterns
    s = '{2047, 2047, 2047, 2047, 2047, 2047, 2047};
    pushBlock(s, "R9 all max");
    sendBlock(s);
    s = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048};
    pushBlock(s, "R9 all min");
    sendBlock(s);
    s = '{2047, -2048, 2047, -2048, 2047, -2048, 2047};
    pushBlock(s, "R9 additive extreme");
    sendBlock(s);
    s = '{-2048, 2047, -2048, 2047, -2048, 2047, -2048};
    pushBlock(s, "R9 negative extreme");
    sendBlock(s);

    repeat (10) feed(1'b0, 0);
    check("R7 every block delivered all beats", qDiff.size(), 0);
    check("R7 idle after last block", int'(outValid), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule